// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block is the in-order completion buffer of an out-of-order core. Each instruction claims a slot at issue, in program order, and the slot records the destination tag, a done flag, a speculative flag and, once execution finishes, the result. Execution units write results back in any order. The oldest slot hands its tag and result to architectural state only when it is done, so register updates always happen in program order.

The buffer tracks at most one unresolved predicted branch. Every instruction issued after that branch and before it resolves is marked speculative, and a speculative slot is held back from retirement. A correct resolution clears all the marks at once. A misprediction drops every marked slot, pulls the allocation pointer back to the slot just after the branch, and raises a one-cycle request to restore the rename map.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `alloc_idx` is 0, `alloc_ready` is 1, and `retire_valid` and `restore_map` are 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready`) takes the slot shown on `alloc_idx`. Slots are handed out in increasing order, wrapping from 15 to 0, and `occupancy` rises by one after the edge unless a retirement happens in the same cycle.
- R3: With 16 slots occupied, `alloc_ready` is 0 and `occupancy` never exceeds 16.
- R4: A write-back (`wb_valid`, `wb_idx`, `wb_data`) marks a valid slot done and stores its result. Results may arrive in any order. `retire_valid` is high only while the oldest slot is done, and it then presents that slot's tag and result. Each cycle with `retire_valid` high removes that slot at the next edge, so retirements follow allocation order.
- R5: A slot allocated while a branch is unresolved is speculative, and the branch's own slot is not. A speculative slot does not retire while it is marked, even if it is done.
- R6: A resolution with `br_mispredict` = 0 clears every speculative mark, and the held slots then retire in order.
- R7: A resolution with `br_mispredict` = 1 removes every speculative slot. After the edge, `occupancy` excludes them and `alloc_idx` points to the slot just after the branch. `restore_map` is 1 for exactly the following cycle, and `alloc_ready` is 0 during the resolving cycle.
- R8: While a branch is unresolved, an allocation with `alloc_is_branch` = 1 is refused (`alloc_ready` = 0).
- R9: A write-back to a slot that is not valid (never allocated, removed, or allocated in that same cycle) has no effect. A slot allocated later at that index is not done.
- R10: A resolution that arrives while no branch is outstanding changes nothing: occupancy, `alloc_idx` and `restore_map` all stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_is_branch | input | 1 | The issuing instruction is a predicted branch |
| alloc_tag | input | 5 | Destination tag of the issuing instruction |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| alloc_idx | output | 4 | Slot given to the next allocation |
| wb_valid | input | 1 | Execution result is present |
| wb_idx | input | 4 | Slot the result belongs to |
| wb_data | input | 32 | Result value |
| br_resolve_valid | input | 1 | The outstanding branch resolves |
| br_mispredict | input | 1 | The resolution was a misprediction |
| retire_valid | output | 1 | Oldest slot retires at the next edge |
| retire_tag | output | 5 | Tag of the retiring slot |
| retire_data | output | 32 | Result of the retiring slot |
| restore_map | output | 1 | One-cycle request to restore the rename map |
| occupancy | output | 5 | Number of occupied slots |

## Verification
All slot and control state is registered, so an allocation, write-back or resolution applied before an edge shows up on `occupancy`, `alloc_idx`, `retire_valid`, `retire_tag` and `retire_data` right after that edge. `restore_map` is high during the cycle after the mispredicting edge. `alloc_ready` is combinational on the current inputs, so it is checked before the edge in the same cycle as the request. The bench drives inputs on the falling edge and samples on the next falling edge, which puts exactly one rising edge between each stimulus and the check of its result.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } br_res_e;

    typedef struct packed {
        logic valid;
        logic done;
        logic spec;
    } slot_flags_t;

endpackage

// File: rtl/rob_slot.sv
module rob_slot
    import spec_rob_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              alloc_spec,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_en,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              clear_spec,
    input  logic              squash,
    input  logic              retire_en,
    output slot_flags_t       flags,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] data
);

    typedef struct packed {
        slot_flags_t       f;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t s_d, s_q;
    logic  dropped;

    always_comb begin
        s_d     = s_q;
        dropped = squash && s_q.f.spec;
        if (retire_en) begin
            s_d.f.valid = 1'b0;
        end
        if (clear_spec) begin
            s_d.f.spec = 1'b0;
        end
        if (dropped) begin
            s_d = '0;
        end else if (wb_en && s_q.f.valid) begin
            s_d.f.done = 1'b1;
            s_d.data   = wb_data;
        end
        if (alloc_en) begin
            s_d.f.valid = 1'b1;
            s_d.f.done  = 1'b0;
            s_d.f.spec  = alloc_spec;
            s_d.tag     = alloc_tag;
            s_d.data    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flags = s_q.f;
    assign tag   = s_q.tag;
    assign data  = s_q.data;

    AST_SQUASH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (squash && s_q.f.spec && !alloc_en) |=> !s_q.f.valid); // R7
    AST_RETIRE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        retire_en |-> (s_q.f.valid && s_q.f.done && !s_q.f.spec)); // R5
    AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> (s_q.f.valid && !s_q.f.done)); // R9

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import spec_rob_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             alloc_is_branch,
    input  br_res_e          res,
    input  logic             head_retirable,
    output logic             alloc_ready,
    output logic             alloc_fire,
    output logic             alloc_spec,
    output logic             retire_fire,
    output logic             squash,
    output logic             clear_spec,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             restore_map
);

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] spec_cnt;
        logic             pend;
        logic             restore;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  hit, miss;

    always_comb begin
        hit         = (res == RES_HIT) && c_q.pend;
        miss        = (res == RES_MISS) && c_q.pend;
        alloc_ready = (c_q.count != CNT_W'(DEPTH)) && !miss
                      && !(alloc_is_branch && c_q.pend);
        alloc_fire  = alloc_valid && alloc_ready;
        alloc_spec  = c_q.pend && !hit;
        retire_fire = head_retirable;

        c_d         = c_q;
        c_d.restore = miss;
        c_d.head    = c_q.head + IDX_W'(retire_fire);
        c_d.count   = c_q.count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
        if (miss) begin
            c_d.tail     = c_q.tail - c_q.spec_cnt[IDX_W-1:0];
            c_d.count    = c_d.count - c_q.spec_cnt;
            c_d.spec_cnt = '0;
            c_d.pend     = 1'b0;
        end else begin
            c_d.tail = c_q.tail + IDX_W'(alloc_fire);
            if (hit) begin
                c_d.spec_cnt = '0;
                c_d.pend     = 1'b0;
            end else if (alloc_fire && alloc_spec) begin
                c_d.spec_cnt = c_q.spec_cnt + 1'b1;
            end
            if (alloc_fire && alloc_is_branch) begin
                c_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign squash      = miss;
    assign clear_spec  = hit;
    assign head        = c_q.head;
    assign tail        = c_q.tail;
    assign count       = c_q.count;
    assign restore_map = c_q.restore;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.count <= CNT_W'(DEPTH)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !retire_fire && !miss) |=> (c_q.count == $past(c_q.count) + 1'b1)); // R2
    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.pend && alloc_valid && alloc_is_branch) |-> !alloc_fire); // R8
    AST_MISS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> (c_q.restore && c_q.spec_cnt == '0 && !c_q.pend)); // R7
    AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (c_q.spec_cnt == '0 && !c_q.restore)); // R6
    AST_SPEC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.spec_cnt <= c_q.count); // R5
    AST_IDLE_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        (res != RES_NONE && !c_q.pend && !alloc_fire && !retire_fire)
        |=> ($stable(c_q.count) && $stable(c_q.tail) && !c_q.restore)); // R10

endmodule

// File: rtl/spec_rob.sv
module spec_rob
    import spec_rob_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_is_branch,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              wb_valid,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              br_resolve_valid,
    input  logic              br_mispredict,
    output logic              retire_valid,
    output logic [TAG_W-1:0]  retire_tag,
    output logic [DATA_W-1:0] retire_data,
    output logic              restore_map,
    output logic [CNT_W-1:0]  occupancy
);

    br_res_e          res;
    logic             alloc_fire, alloc_spec, retire_fire, squash, clear_spec;
    logic [IDX_W-1:0] head, tail;
    slot_flags_t      flags_arr [DEPTH];
    logic [TAG_W-1:0] tag_arr   [DEPTH];
    logic [DATA_W-1:0] data_arr [DEPTH];
    slot_flags_t      head_f;

    always_comb begin
        if (!br_resolve_valid) begin
            res = RES_NONE;
        end else if (br_mispredict) begin
            res = RES_MISS;
        end else begin
            res = RES_HIT;
        end
    end

    assign head_f = flags_arr[head];

    rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .alloc_valid     (alloc_valid),
        .alloc_is_branch (alloc_is_branch),
        .res             (res),
        .head_retirable  (head_f.valid && head_f.done && !head_f.spec),
        .alloc_ready     (alloc_ready),
        .alloc_fire      (alloc_fire),
        .alloc_spec      (alloc_spec),
        .retire_fire     (retire_fire),
        .squash          (squash),
        .clear_spec      (clear_spec),
        .head            (head),
        .tail            (tail),
        .count           (occupancy),
        .restore_map     (restore_map)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_fire && tail == IDX_W'(i)),
            .alloc_spec (alloc_spec),
            .alloc_tag  (alloc_tag),
            .wb_en      (wb_valid && wb_idx == IDX_W'(i)),
            .wb_data    (wb_data),
            .clear_spec (clear_spec),
            .squash     (squash),
            .retire_en  (retire_fire && head == IDX_W'(i)),
            .flags      (flags_arr[i]),
            .tag        (tag_arr[i]),
            .data       (data_arr[i])
        );
    end

    assign alloc_idx    = tail;
    assign retire_valid = retire_fire;
    assign retire_tag   = tag_arr[head];
    assign retire_data  = data_arr[head];

    AST_RETIRE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (occupancy != '0)); // R4
    AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_map |=> !restore_map); // R7

endmodule

// File: tb/spec_rob_test.sv
module spec_rob_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, alloc_is_branch = 1'b0;
    logic [4:0]  alloc_tag = '0;
    logic        alloc_ready;
    logic [3:0]  alloc_idx;
    logic        wb_valid = 1'b0;
    logic [3:0]  wb_idx = '0;
    logic [31:0] wb_data = '0;
    logic        br_resolve_valid = 1'b0, br_mispredict = 1'b0;
    logic        retire_valid;
    logic [4:0]  retire_tag;
    logic [31:0] retire_data;
    logic        restore_map;
    logic [4:0]  occupancy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    spec_rob uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_is_branch(alloc_is_branch),
        .alloc_tag(alloc_tag), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .br_resolve_valid(br_resolve_valid), .br_mispredict(br_mispredict),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .retire_data(retire_data), .restore_map(restore_map),
        .occupancy(occupancy)
    );

    typedef struct packed {
        logic        av;
        logic [4:0]  atag;
        logic        wv;
        logic [3:0]  widx;
        logic [31:0] wdat;
        logic [4:0]  exp_cnt;
        logic        exp_rv;
        logic [4:0]  exp_tag;
        logic [31:0] exp_dat;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 5'd3, 1'b0, 4'd0, 32'h0,  5'd1, 1'b0, 5'd0, 32'h0},
        '{1'b1, 5'd4, 1'b0, 4'd0, 32'h0,  5'd2, 1'b0, 5'd0, 32'h0},
        '{1'b0, 5'd0, 1'b1, 4'd1, 32'h44, 5'd2, 1'b0, 5'd0, 32'h0},
        '{1'b0, 5'd0, 1'b1, 4'd0, 32'h33, 5'd2, 1'b1, 5'd3, 32'h33},
        '{1'b0, 5'd0, 1'b0, 4'd0, 32'h0,  5'd1, 1'b1, 5'd4, 32'h44},
        '{1'b0, 5'd0, 1'b0, 4'd0, 32'h0,  5'd0, 1'b0, 5'd0, 32'h0},
        '{1'b1, 5'd7, 1'b1, 4'd2, 32'h99, 5'd1, 1'b0, 5'd0, 32'h0},
        '{1'b0, 5'd0, 1'b0, 4'd0, 32'h0,  5'd1, 1'b0, 5'd0, 32'h0},
        '{1'b0, 5'd0, 1'b1, 4'd2, 32'h77, 5'd1, 1'b1, 5'd7, 32'h77},
        '{1'b0, 5'd0, 1'b0, 4'd0, 32'h0,  5'd0, 1'b0, 5'd0, 32'h0}
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0; alloc_is_branch = 1'b0; alloc_tag = '0;
        wb_valid = 1'b0; wb_idx = '0; wb_data = '0;
        br_resolve_valid = 1'b0; br_mispredict = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic alloc(input logic [4:0] t, input logic br);
        alloc_valid = 1'b1; alloc_tag = t; alloc_is_branch = br;
        step();
    endtask

    task automatic wb(input logic [3:0] i, input logic [31:0] d);
        wb_valid = 1'b1; wb_idx = i; wb_data = d;
        step();
    endtask

    initial begin
        do_reset();
        chk("R1", "occupancy", occupancy, 0);
        chk("R1", "alloc_idx", alloc_idx, 0);
        chk("R1", "alloc_ready", alloc_ready, 1);
        chk("R1", "retire_valid", retire_valid, 0);
        chk("R1", "restore_map", restore_map, 0);

        // R2 R4 R9: vector table, one cycle per row, checked after the edge
        foreach (VECS[k]) begin
            alloc_valid = VECS[k].av; alloc_tag = VECS[k].atag;
            wb_valid = VECS[k].wv; wb_idx = VECS[k].widx; wb_data = VECS[k].wdat;
            step();
            chk("R4", $sformatf("row %0d occupancy", k), occupancy, VECS[k].exp_cnt);
            chk("R4", $sformatf("row %0d retire_valid", k), retire_valid, VECS[k].exp_rv);
            if (VECS[k].exp_rv) begin
                chk("R4", $sformatf("row %0d retire_tag", k), retire_tag, VECS[k].exp_tag);
                chk("R4", $sformatf("row %0d retire_data", k), retire_data, VECS[k].exp_dat);
            end
        end

        // R2 R3: fill from slot 3 with wrap, then refuse
        for (int i = 0; i < 16; i++) begin
            chk("R2", "alloc_idx order", alloc_idx, (3 + i) % 16);
            alloc(5'(i), 1'b0);
        end
        chk("R3", "full occupancy", occupancy, 16);
        alloc_valid = 1'b1;
        #0.1;
        chk("R3", "ready low when full", alloc_ready, 0);
        step();
        chk("R3", "still 16", occupancy, 16);
        // R4: write back youngest first, head last
        for (int i = 15; i >= 1; i--) wb(4'((3 + i) % 16), 32'h100 + i);
        chk("R4", "head not done holds", retire_valid, 0);
        wb(4'd3, 32'h100);
        for (int i = 0; i < 16; i++) begin
            chk("R4", "in-order retire_valid", retire_valid, 1);
            chk("R4", "in-order tag", retire_tag, i);
            chk("R4", "in-order data", retire_data, 32'h100 + i);
            step();
        end
        chk("R4", "drained", occupancy, 0);

        // R5 R6 R8: correctly predicted branch
        do_reset();
        alloc(5'd1, 1'b1);
        alloc(5'd2, 1'b0);
        alloc(5'd3, 1'b0);
        alloc_valid = 1'b1; alloc_is_branch = 1'b1; alloc_tag = 5'd9;
        #0.1;
        chk("R8", "second branch refused", alloc_ready, 0);
        step();
        chk("R8", "occupancy unchanged", occupancy, 3);
        wb(4'd1, 32'h22);
        wb(4'd2, 32'h23);
        wb(4'd0, 32'h21);
        chk("R5", "branch retires", retire_valid, 1);
        chk("R5", "branch tag", retire_tag, 1);
        step();
        for (int c = 0; c < 3; c++) begin
            chk("R5", "speculative done held", retire_valid, 0);
            step();
        end
        chk("R5", "held occupancy", occupancy, 2);
        br_resolve_valid = 1'b1; br_mispredict = 1'b0;
        step();
        chk("R6", "retire after clear", retire_valid, 1);
        chk("R6", "tag after clear", retire_tag, 2);
        chk("R6", "no restore", restore_map, 0);
        step();
        chk("R6", "second retire tag", retire_tag, 3);
        chk("R6", "second retire data", retire_data, 32'h23);

        // R7 R9: mispredicted branch
        do_reset();
        alloc(5'd10, 1'b0);
        alloc(5'd11, 1'b1);
        alloc(5'd12, 1'b0);
        alloc(5'd13, 1'b0);
        wb(4'd2, 32'hC);
        br_resolve_valid = 1'b1; br_mispredict = 1'b1;
        alloc_valid = 1'b1; alloc_tag = 5'd30;
        #0.1;
        chk("R7", "ready low in squash cycle", alloc_ready, 0);
        step();
        chk("R7", "occupancy after squash", occupancy, 2);
        chk("R7", "tail back", alloc_idx, 2);
        chk("R7", "restore pulse", restore_map, 1);
        step();
        chk("R7", "restore one cycle", restore_map, 0);
        wb(4'd2, 32'hDEAD);
        chk("R9", "stray wb no occupancy", occupancy, 2);
        alloc(5'd20, 1'b0);
        wb(4'd0, 32'hA0);
        chk("R7", "retire survivor", retire_tag, 10);
        wb(4'd1, 32'hB0);
        chk("R7", "retire branch", retire_tag, 11);
        step();
        chk("R9", "realloc slot not done", retire_valid, 0);
        wb(4'd2, 32'h20);
        chk("R9", "realloc retire", retire_valid, 1);
        chk("R9", "realloc data", retire_data, 32'h20);
        step();

        // R10: resolution with no branch outstanding
        br_resolve_valid = 1'b1; br_mispredict = 1'b1;
        step();
        chk("R10", "occupancy", occupancy, 0);
        chk("R10", "alloc_idx", alloc_idx, 3);
        chk("R10", "no restore", restore_map, 0);

        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule